// File: doc/BRIEF.md
# Auxiliary Address Register Unit

This block holds a small file of auxiliary address registers and the arithmetic that steps them after each indirect access. A pointer names the current register. Its value is shown on the address output for the access in progress. On the clock edge that ends the access, the register is rewritten by the selected update. The update can be a unit step up or down, a step by the index register (register 0), a reverse-carry step by the index, or a short immediate step. Reverse-carry steps let an FFT-style loop walk a buffer in bit-reversed order. The carry or borrow of these steps runs from the most significant bit down toward bit 0.

The same operation can also load a new pointer value, so the next access uses another register. A separate load port writes any register directly. When the load port and the update hit the same register, the load wins. A compare operation tests the current register against the index register, unsigned, in one of four modes. The result goes to a single test flag, which keeps its value until the next compare. Operation decode, memory and the accumulator live outside the block.

Top module: `aux_addr_unit`

## Requirements
- R1: While rst_n is low, every register, the pointer and the flag are held at zero. Directly after release, addr_o reads 0000h.
- R2: addr_o shows the current register before its update. Op 1 adds one and op 2 subtracts one, modulo 2^16 (7FFFh+1=8000h, 0000h-1=FFFFh).
- R3: Op 3 adds register 0 to the current register and op 4 subtracts it, modulo 2^16. For example, C000h+7FFFh=3FFFh and 6000h-7FFFh=E001h.
- R4: Op 5 and op 6 add and subtract register 0 with the carry running from the top bit downward. With register 0 = 7FFFh, op 5 turns 3FFFh into 5FFFh and op 6 turns 8000h into C000h.
- R5: Op 7 adds the 8-bit unsigned imm_i to the current register and op 8 subtracts it, modulo 2^16. Examples: 5FFFh+1=6000h, E000h-2=DFFEh, 0000h+FFh=00FFh.
- R6: Op 9 sets tc_o to 1 when its test is true and to 0 when false. cmp_mode_i selects the test: 0 is equal, 1 is current < register 0, 2 is current > register 0, 3 is not equal. tc_o keeps its value under every other op.
- R7: The compare is unsigned. With current DFFEh, register 0 = DFFDh makes mode 2 true and register 0 = DFFFh makes mode 1 true. With pointer 0 under mode 0, the flag is set.
- R8: With ptr_ld_i high, the pointer takes ptr_val_i at the same edge as the update. The update still applies to the register the old pointer selected.
- R9: With ld_en_i high, register ld_sel_i takes ld_val_i. This takes priority over an update of the same register, and leaves an update of a different register intact.
- R10: Op 0 and the unused codes 10 to 15 change no register. An update never changes any register other than the current one.
- R11: A compare changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (R2 to R6, R10) |
| imm_i | input | 8 | Short unsigned immediate |
| cmp_mode_i | input | 2 | Compare test select |
| ptr_ld_i | input | 1 | Load pointer at end of this operation |
| ptr_val_i | input | 3 | New pointer value |
| ld_en_i | input | 1 | Direct register load enable |
| ld_sel_i | input | 3 | Register chosen for the direct load |
| ld_val_i | input | 16 | Value for the direct load |
| addr_o | output | 16 | Current register value, before update |
| ptr_o | output | 3 | Current pointer |
| regs_o | output | 128 | All registers, register k at bits 16k+15 : 16k |
| tc_o | output | 1 | Test flag from the last compare |

## Verification
The checker assumes that the inputs are driven to known values whenever reset is released. It also assumes that a register number on ld_sel_i or ptr_val_i always names an existing register, which holds because the register count is a power of two. The bench drives every input from tasks a short delay after the rising edge and returns the op code to 0 between scenarios. This keeps the properties that depend on the op code unambiguous. Each scenario uses only documented op codes, except the one that deliberately feeds unused codes to confirm that they do nothing.

// File: rtl/aau_pkg.sv
package aau_pkg;
   typedef enum logic [3:0] {
      AAU_NOP     = 4'd0,
      AAU_INC     = 4'd1,
      AAU_DEC     = 4'd2,
      AAU_IDX_ADD = 4'd3,
      AAU_IDX_SUB = 4'd4,
      AAU_REV_ADD = 4'd5,
      AAU_REV_SUB = 4'd6,
      AAU_IMM_ADD = 4'd7,
      AAU_IMM_SUB = 4'd8,
      AAU_CMP     = 4'd9
   } aau_op_e;

   typedef enum logic [1:0] {
      CMP_EQ = 2'd0,
      CMP_LT = 2'd1,
      CMP_GT = 2'd2,
      CMP_NE = 2'd3
   } aau_cmp_e;
endpackage

// File: rtl/aau_alu.sv
module aau_alu
   import aau_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMM_W  = 8,
   parameter bit REV_EN = 1'b1
) (
   input  aau_op_e           op_i,
   input  logic [DATA_W-1:0] cur_i,
   input  logic [DATA_W-1:0] idx_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic              upd_o,
   output logic [DATA_W-1:0] nxt_o
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] rsum;
   logic [DATA_W-1:0] rdif;
   logic              rev_ok;

   assign imm_ext = DATA_W'(imm_i);

   // reverse-carry: mirror both operands, plain add/sub, mirror back
   generate
      if (REV_EN) begin : g_rev
         logic [DATA_W-1:0] cur_m;
         logic [DATA_W-1:0] idx_m;
         logic [DATA_W-1:0] sum_m;
         logic [DATA_W-1:0] dif_m;
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign cur_m[b] = cur_i[DATA_W-1-b];
            assign idx_m[b] = idx_i[DATA_W-1-b];
            assign rsum[b]  = sum_m[DATA_W-1-b];
            assign rdif[b]  = dif_m[DATA_W-1-b];
         end
         assign sum_m  = cur_m + idx_m;
         assign dif_m  = cur_m - idx_m;
         assign rev_ok = 1'b1;
      end else begin : g_norev
         assign rsum   = cur_i;
         assign rdif   = cur_i;
         assign rev_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      upd_o = 1'b1;
      nxt_o = cur_i;
      case (op_i)
         AAU_INC:     nxt_o = cur_i + ONE;
         AAU_DEC:     nxt_o = cur_i - ONE;
         AAU_IDX_ADD: nxt_o = cur_i + idx_i;
         AAU_IDX_SUB: nxt_o = cur_i - idx_i;
         AAU_REV_ADD: begin nxt_o = rsum; upd_o = rev_ok; end
         AAU_REV_SUB: begin nxt_o = rdif; upd_o = rev_ok; end
         AAU_IMM_ADD: nxt_o = cur_i + imm_ext;
         AAU_IMM_SUB: nxt_o = cur_i - imm_ext;
         default:     upd_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/aau_cmp.sv
module aau_cmp
   import aau_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  aau_op_e           op_i,
   input  aau_cmp_e          mode_i,
   input  logic [DATA_W-1:0] cur_i,
   input  logic [DATA_W-1:0] idx_i,
   output logic              tc_o
);
   logic hit;

   always_comb begin
      unique case (mode_i)
         CMP_EQ:  hit = (cur_i == idx_i);
         CMP_LT:  hit = (cur_i <  idx_i);
         CMP_GT:  hit = (cur_i >  idx_i);
         default: hit = (cur_i != idx_i);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tc_o <= 1'b0;
      else if (op_i == AAU_CMP) tc_o <= hit;
   end
endmodule

// File: rtl/aau_regfile.sv
module aau_regfile #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter int PTR_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_en_i,
   input  logic [DATA_W-1:0]          upd_val_i,
   input  logic                       ptr_ld_i,
   input  logic [PTR_W-1:0]           ptr_val_i,
   input  logic                       ld_en_i,
   input  logic [PTR_W-1:0]           ld_sel_i,
   input  logic [DATA_W-1:0]          ld_val_i,
   output logic [PTR_W-1:0]           ptr_o,
   output logic [DATA_W-1:0]          cur_o,
   output logic [DATA_W-1:0]          idx_o,
   output logic [NUM_REGS*DATA_W-1:0] flat_o
);
   logic [DATA_W-1:0] mem [NUM_REGS];

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[k] <= '0;
            else if (ld_en_i && (ld_sel_i == PTR_W'(k)))
               mem[k] <= ld_val_i;
            else if (upd_en_i && (ptr_o == PTR_W'(k)))
               mem[k] <= upd_val_i;
         end
         assign flat_o[k*DATA_W +: DATA_W] = mem[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_o <= '0;
      else if (ptr_ld_i) ptr_o <= ptr_val_i;
   end

   assign cur_o = mem[ptr_o];
   assign idx_o = mem[0];
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit
   import aau_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter int IMM_W    = 8,
   parameter bit REV_EN   = 1'b1,
   localparam int PTR_W   = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [3:0]                 op_i,
   input  logic [IMM_W-1:0]           imm_i,
   input  logic [1:0]                 cmp_mode_i,
   input  logic                       ptr_ld_i,
   input  logic [PTR_W-1:0]           ptr_val_i,
   input  logic                       ld_en_i,
   input  logic [PTR_W-1:0]           ld_sel_i,
   input  logic [DATA_W-1:0]          ld_val_i,
   output logic [DATA_W-1:0]          addr_o,
   output logic [PTR_W-1:0]           ptr_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o,
   output logic                       tc_o
);
   generate
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
         $error("NUM_REGS must be a power of two, at least 2");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("IMM_W must lie in 1..DATA_W");
      end
   endgenerate

   aau_op_e           op;
   aau_cmp_e          mode;
   logic [DATA_W-1:0] cur;
   logic [DATA_W-1:0] idx;
   logic [DATA_W-1:0] nxt;
   logic              upd;

   assign op   = aau_op_e'(op_i);
   assign mode = aau_cmp_e'(cmp_mode_i);

   aau_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en_i  (upd),
      .upd_val_i (nxt),
      .ptr_ld_i  (ptr_ld_i),
      .ptr_val_i (ptr_val_i),
      .ld_en_i   (ld_en_i),
      .ld_sel_i  (ld_sel_i),
      .ld_val_i  (ld_val_i),
      .ptr_o     (ptr_o),
      .cur_o     (cur),
      .idx_o     (idx),
      .flat_o    (regs_o)
   );

   aau_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REV_EN(REV_EN)) u_alu (
      .op_i  (op),
      .cur_i (cur),
      .idx_i (idx),
      .imm_i (imm_i),
      .upd_o (upd),
      .nxt_o (nxt)
   );

   aau_cmp #(.DATA_W(DATA_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (op),
      .mode_i (mode),
      .cur_i  (cur),
      .idx_i  (idx),
      .tc_o   (tc_o)
   );

   assign addr_o = cur;
endmodule

// File: rtl/aau_checker.sv
module aau_checker #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter int IMM_W    = 8,
   parameter int PTR_W    = $clog2(NUM_REGS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [3:0]                 op_i,
   input logic [IMM_W-1:0]           imm_i,
   input logic [1:0]                 cmp_mode_i,
   input logic                       ptr_ld_i,
   input logic [PTR_W-1:0]           ptr_val_i,
   input logic                       ld_en_i,
   input logic [PTR_W-1:0]           ld_sel_i,
   input logic [DATA_W-1:0]          ld_val_i,
   input logic [DATA_W-1:0]          addr_o,
   input logic [PTR_W-1:0]           ptr_o,
   input logic [NUM_REGS*DATA_W-1:0] regs_o,
   input logic                       tc_o
);
   logic [DATA_W-1:0] arr [NUM_REGS];
   logic [DATA_W-1:0] ar0;
   logic [DATA_W-1:0] inc_exp;
   logic              self_ld;

   always_comb begin
      for (int k = 0; k < NUM_REGS; k++) arr[k] = regs_o[k*DATA_W +: DATA_W];
   end
   assign ar0     = regs_o[DATA_W-1:0];
   assign inc_exp = addr_o + DATA_W'(1);
   assign self_ld = ld_en_i && (ld_sel_i == ptr_o);

   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_ld_i |=> ptr_o == $past(ptr_val_i)); // R8
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_ld_i |=> $stable(ptr_o)); // R8
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd1 && !self_ld) |=> arr[$past(ptr_o)] == $past(inc_exp)); // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en_i |=> arr[$past(ld_sel_i)] == $past(ld_val_i)); // R9
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 4'd0 || op_i > 4'd9) && !ld_en_i) |=> $stable(regs_o)); // R10
   AST_TC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      op_i != 4'd9 |=> $stable(tc_o)); // R6
   AST_CMP_GT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9 && cmp_mode_i == 2'd2) |=> tc_o == ($past(addr_o) > $past(ar0))); // R7
   AST_CMP_EQ: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9 && cmp_mode_i == 2'd0) |=> tc_o == ($past(addr_o) == $past(ar0))); // R6
   AST_CMP_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd9 && !ld_en_i) |=> $stable(regs_o)); // R11
endmodule

bind aux_addr_unit aau_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IMM_W(IMM_W)
) u_aau_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_i       (op_i),
   .imm_i      (imm_i),
   .cmp_mode_i (cmp_mode_i),
   .ptr_ld_i   (ptr_ld_i),
   .ptr_val_i  (ptr_val_i),
   .ld_en_i    (ld_en_i),
   .ld_sel_i   (ld_sel_i),
   .ld_val_i   (ld_val_i),
   .addr_o     (addr_o),
   .ptr_o      (ptr_o),
   .regs_o     (regs_o),
   .tc_o       (tc_o)
);

// File: tb/aux_addr_unit_bench.sv
module aux_addr_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   op_i = '0;
   logic [7:0]   imm_i = '0;
   logic [1:0]   cmp_mode_i = '0;
   logic         ptr_ld_i = 1'b0;
   logic [2:0]   ptr_val_i = '0;
   logic         ld_en_i = 1'b0;
   logic [2:0]   ld_sel_i = '0;
   logic [15:0]  ld_val_i = '0;
   logic [15:0]  addr_o;
   logic [2:0]   ptr_o;
   logic [127:0] regs_o;
   logic         tc_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aux_addr_unit u_aux_addr_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i),
      .cmp_mode_i(cmp_mode_i), .ptr_ld_i(ptr_ld_i), .ptr_val_i(ptr_val_i),
      .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_val_i(ld_val_i),
      .addr_o(addr_o), .ptr_o(ptr_o), .regs_o(regs_o), .tc_o(tc_o)
   );

   function automatic logic [15:0] rd(input int k);
      return regs_o[k*16 +: 16];
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one operation, driven just after an edge, results visible after the next edge
   task automatic run(input logic [3:0] op, input logic [7:0] imm = 8'd0,
                      input logic [1:0] mode = 2'd0);
      op_i = op; imm_i = imm; cmp_mode_i = mode;
      @(posedge clk); #1;
      op_i = 4'd0; imm_i = '0; cmp_mode_i = '0;
   endtask

   task automatic load(input logic [2:0] sel, input logic [15:0] val);
      ld_en_i = 1'b1; ld_sel_i = sel; ld_val_i = val;
      @(posedge clk); #1;
      ld_en_i = 1'b0;
   endtask

   task automatic point(input logic [2:0] p);
      ptr_ld_i = 1'b1; ptr_val_i = p;
      @(posedge clk); #1;
      ptr_ld_i = 1'b0;
   endtask

   task automatic t_reset;
      for (int k = 0; k < 8; k++) chk("R1 reg", rd(k), 16'h0000);
      chk("R1 ptr", 16'(ptr_o), 16'h0);
      chk("R1 tc", 16'(tc_o), 16'h0);
      chk("R1 addr", addr_o, 16'h0000);
   endtask

   task automatic t_chain;
      load(3'd0, 16'h7FFF);
      load(3'd3, 16'h7FFF);
      point(3'd3);
      chk("R2 addr before update", addr_o, 16'h7FFF);
      run(4'd1); chk("R2 inc", rd(3), 16'h8000);
      run(4'd6); chk("R4 rev sub", rd(3), 16'hC000);
      run(4'd3); chk("R3 idx add", rd(3), 16'h3FFF);
      run(4'd5); chk("R4 rev add", rd(3), 16'h5FFF);
      run(4'd7, 8'd1); chk("R5 imm add", rd(3), 16'h6000);
      run(4'd4); chk("R3 idx sub", rd(3), 16'hE001);
      run(4'd2); chk("R2 dec", rd(3), 16'hE000);
      run(4'd8, 8'd2); chk("R5 imm sub", rd(3), 16'hDFFE);
      chk("R10 index reg untouched", rd(0), 16'h7FFF);
      chk("R10 other reg untouched", rd(4), 16'h0000);
   endtask

   task automatic t_compare;
      // current = AR3 = DFFE
      load(3'd0, 16'hDFFE);
      run(4'd9, 8'd0, 2'd0); chk("R6 eq true", 16'(tc_o), 16'h1);
      run(4'd0); chk("R6 tc holds", 16'(tc_o), 16'h1);
      run(4'd9, 8'd0, 2'd1); chk("R6 lt false", 16'(tc_o), 16'h0);
      run(4'd9, 8'd0, 2'd2); chk("R6 gt false", 16'(tc_o), 16'h0);
      run(4'd9, 8'd0, 2'd3); chk("R6 ne false", 16'(tc_o), 16'h0);
      load(3'd0, 16'hDFFD);
      run(4'd9, 8'd0, 2'd0); chk("R6 eq false", 16'(tc_o), 16'h0);
      run(4'd9, 8'd0, 2'd1); chk("R7 lt false", 16'(tc_o), 16'h0);
      run(4'd9, 8'd0, 2'd2); chk("R7 gt true", 16'(tc_o), 16'h1);
      run(4'd9, 8'd0, 2'd3); chk("R6 ne true", 16'(tc_o), 16'h1);
      load(3'd0, 16'hDFFF);
      run(4'd9, 8'd0, 2'd1); chk("R7 lt true", 16'(tc_o), 16'h1);
      run(4'd9, 8'd0, 2'd2); chk("R7 gt false", 16'(tc_o), 16'h0);
      chk("R11 cmp leaves reg", rd(3), 16'hDFFE);
      point(3'd0);
      run(4'd9, 8'd0, 2'd0); chk("R7 self compare", 16'(tc_o), 16'h1);
      chk("R11 cmp leaves index", rd(0), 16'hDFFF);
   endtask

   task automatic t_wrap;
      load(3'd2, 16'h0000);
      point(3'd2);
      run(4'd2); chk("R2 dec wrap", rd(2), 16'hFFFF);
      run(4'd1); chk("R2 inc wrap", rd(2), 16'h0000);
      run(4'd7, 8'hFF); chk("R5 imm unsigned", rd(2), 16'h00FF);
   endtask

   task automatic t_ptr;
      load(3'd1, 16'h0010);
      load(3'd5, 16'h0500);
      point(3'd1);
      ptr_ld_i = 1'b1; ptr_val_i = 3'd5;
      run(4'd1);
      ptr_ld_i = 1'b0;
      chk("R8 old reg updated", rd(1), 16'h0011);
      chk("R8 ptr loaded", 16'(ptr_o), 16'h5);
      chk("R8 new addr", addr_o, 16'h0500);
   endtask

   task automatic t_load_prio;
      // pointer is 5
      ld_en_i = 1'b1; ld_sel_i = 3'd5; ld_val_i = 16'h1234;
      run(4'd1);
      ld_en_i = 1'b0;
      chk("R9 load beats update", rd(5), 16'h1234);
      ld_en_i = 1'b1; ld_sel_i = 3'd6; ld_val_i = 16'hAAAA;
      run(4'd1);
      ld_en_i = 1'b0;
      chk("R9 update kept", rd(5), 16'h1235);
      chk("R9 other load", rd(6), 16'hAAAA);
   endtask

   task automatic t_idle;
      logic [127:0] snap;
      snap = regs_o;
      run(4'd0);
      chk("R10 op0 low half", snap[63:0] == regs_o[63:0] ? 16'h1 : 16'h0, 16'h1);
      run(4'd15);
      run(4'd10);
      chk("R10 unused codes", snap == regs_o ? 16'h1 : 16'h0, 16'h1);
      chk("R10 current kept", rd(5), 16'h1235);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after release", addr_o, 16'h0000);
      t_chain;
      t_compare;
      t_wrap;
      t_ptr;
      t_load_prio;
      t_idle;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule